// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer for an always-on power domain. It runs from the slow always-on clock, so one clock cycle is one tick. Software reaches it through a small 32-bit register bus that is write-strobed and read combinationally. The block holds a 31-bit free-running count, a scale field that selects which 16-bit window of the count is compared, and a 16-bit compare value. When the selected window reaches or passes the compare value, an interrupt-pending flag is set. Optionally, a single-cycle reset request is raised, and the count can be cleared so that the block works as a periodic timer.

Every write to a protected register must follow an unlock write of the magic word 0x0051F15E to the key register. The unlock is used up by the next protected write, whether or not that write takes effect. A stray software store therefore cannot feed, reconfigure or disarm the watchdog. Counting can run all the time or only while the core is awake, which a core-reset status input from the wakeup sequencer reports.

Register word addresses are CTRL=0, KEY=1, FEED=2, COUNT=3, SCALED=4 and CMP=5. The CTRL fields are:

- scale in bits [3:0]
- reset enable in bit 8
- zero-on-match in bit 9
- always-run in bit 12
- awake-run in bit 13
- interrupt pending in bit 28

Top module: `wdt_keyed`

## Requirements
- R1: After reset, CTRL, COUNT and the key state read 0, CMP reads 0xFFFF, and both wdt_irq and wdt_rst_req are low.
- R2: A write of exactly 0x0051F15E to KEY (address 1) sets the key state, which reads back in KEY bit 0. A write of any other value to KEY clears it.
- R3: Writes to CTRL, FEED, COUNT, SCALED and CMP (addresses 0, 2, 3, 4, 5) take effect only while the key state is set. Any write to one of these addresses clears the key state.
- R4: COUNT bits [30:0] are readable and writable, bit 31 always reads 0, and the count wraps from 0x7FFFFFFF to 0.
- R5: With CTRL bit 12 set, the count increments on every clock. With only CTRL bit 13 set, it increments only while core_rst is low. With neither bit set, it holds.
- R6: An effective write to FEED, with any data, clears the count.
- R7: SCALED reads count bits [scale+15:scale], where scale is CTRL[3:0].
- R8: When SCALED is greater than or equal to CMP, the pending bit CTRL[28] and wdt_irq are high from the next cycle on. An effective CTRL write with bit 28 at 0 clears the bit, unless the match still holds.
- R9: With CTRL bit 8 set, wdt_rst_req pulses high for exactly one cycle, in the cycle after a match begins.
- R10: With CTRL bit 9 set, a match clears the count on the next clock.
- R11: An effective write to SCALED changes no register; it only uses up the key.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow always-on clock; one tick per cycle |
| rst_n | input | 1 | Active-low asynchronous reset |
| core_rst | input | 1 | High while the core is held in reset or asleep |
| bus_wr | input | 1 | Write strobe for the register bus |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| wdt_irq | output | 1 | Interrupt-pending flag |
| wdt_rst_req | output | 1 | One-cycle system reset request |

## Verification
On every cycle, the in-RTL assertions check the following:

- the key is used up by each protected write;
- locked writes leave CMP and the scale untouched;
- the count either steps by one or holds, according to the run enables;
- a match always raises the pending flag, and the flag stays set until software clears it;
- the reset request never lasts two cycles.

Some behaviour only the bench's scenarios can show. These are the exact magic value, the wrap at 31 bits, the window selection for each scale, the awake-only gating as core_rst toggles, the periodic clear-and-pulse cadence, and that a write to SCALED changes nothing. The bench covers them by comparing a behavioural model on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
   // Register word addresses
   localparam int ADR_CTRL   = 0;
   localparam int ADR_KEY    = 1;
   localparam int ADR_FEED   = 2;
   localparam int ADR_COUNT  = 3;
   localparam int ADR_SCALED = 4;
   localparam int ADR_CMP    = 5;

   // CTRL bit positions
   localparam int CB_RSTEN  = 8;
   localparam int CB_ZERO   = 9;
   localparam int CB_ALWAYS = 12;
   localparam int CB_AWAKE  = 13;
   localparam int CB_IP     = 28;

   localparam logic [31:0] WDT_MAGIC = 32'h0051_F15E;

   // Effective (key-qualified) write strobes
   typedef struct packed {
      logic ctrl;
      logic feed;
      logic count;
      logic scaled;
      logic cmp;
   } wdt_wstb_t;
endpackage

// File: rtl/wdt_keylock.sv
module wdt_keylock #(
   parameter int          KEY_W   = 32,
   parameter logic [31:0] KEY_VAL = 32'h0051_F15E
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             key_wr,
   input  logic [KEY_W-1:0] key_data,
   input  logic             prot_wr,
   output logic             key_open
);
   localparam logic [KEY_W-1:0] MAGIC = KEY_W'(KEY_VAL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       key_open <= 1'b0;
      else if (key_wr)  key_open <= (key_data == MAGIC);
      else if (prot_wr) key_open <= 1'b0;
   end

   AST_KEY_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
      prot_wr |=> !key_open); // R3
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int CNT_W      = 31,
   parameter int CMP_W      = 16,
   parameter int SCALE_W    = 4,
   parameter bit HAS_AWAKE  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               run_always,
   input  logic               run_awake,
   input  logic               core_rst,
   input  logic               load,
   input  logic [CNT_W-1:0]   load_val,
   input  logic               clear,
   input  logic [SCALE_W-1:0] scale,
   output logic [CNT_W-1:0]   count,
   output logic [CMP_W-1:0]   scaled
);
   localparam int NWIN = 2 ** SCALE_W;

   if (CMP_W + NWIN - 1 > CNT_W) begin : g_chk_win
      $error("wdt_counter: count too narrow for the largest scale window");
   end

   logic cnt_en;

   if (HAS_AWAKE) begin : g_awake
      assign cnt_en = run_always | (run_awake & ~core_rst);
   end else begin : g_always_only
      logic unused_awake;
      assign unused_awake = run_awake ^ core_rst;
      assign cnt_en = run_always;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      count <= '0;
      else if (load)   count <= load_val;
      else if (clear)  count <= '0;
      else if (cnt_en) count <= count + CNT_W'(1);
   end

   // One candidate window per scale value
   logic [CMP_W-1:0] win [NWIN];
   for (genvar s = 0; s < NWIN; s++) begin : g_win
      assign win[s] = count[s +: CMP_W];
   end
   assign scaled = win[scale];

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_en && !load && !clear) |=> count == $past(count) + CNT_W'(1)); // R5
   AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_en && !load && !clear) |=> $stable(count)); // R5
endmodule

// File: rtl/wdt_compare.sv
module wdt_compare #(
   parameter int CMP_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CMP_W-1:0] scaled,
   input  logic [CMP_W-1:0] cmp,
   input  logic             rst_en,
   input  logic             ip_wr,
   input  logic             ip_wdata,
   output logic             match,
   output logic             ip,
   output logic             rst_req
);
   logic match_q;

   assign match = (scaled >= cmp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         match_q <= 1'b0;
         ip      <= 1'b0;
         rst_req <= 1'b0;
      end else begin
         match_q <= match;
         ip      <= (ip_wr ? ip_wdata : ip) | match;
         rst_req <= rst_en & match & ~match_q;
      end
   end

   AST_MATCH_SETS_IP: assert property (@(posedge clk) disable iff (!rst_n)
      match |=> ip); // R8
   AST_IP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ip && !ip_wr) |=> ip); // R8
   AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |=> !rst_req); // R9
   AST_RST_WITH_IP: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> ip); // R9
endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
   import wdt_pkg::*;
#(
   parameter int          BUS_W     = 32,
   parameter int          ADDR_W    = 3,
   parameter int          CNT_W     = 31,
   parameter int          CMP_W     = 16,
   parameter int          SCALE_W   = 4,
   parameter bit          HAS_AWAKE = 1'b1,
   parameter logic [31:0] KEY_VAL   = WDT_MAGIC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              core_rst,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              wdt_irq,
   output logic              wdt_rst_req
);
   if (CNT_W >= BUS_W) begin : g_chk_cnt
      $error("wdt_keyed: count must leave the top bus bit free");
   end
   if (CB_IP >= BUS_W || SCALE_W > CB_RSTEN) begin : g_chk_ctrl
      $error("wdt_keyed: control fields do not fit the bus");
   end
   if (ADDR_W < 3) begin : g_chk_addr
      $error("wdt_keyed: address too narrow for six registers");
   end

   // Address decode
   logic hit_ctrl, hit_key, hit_feed, hit_count, hit_scaled, hit_cmp;
   assign hit_ctrl   = (bus_addr == ADDR_W'(ADR_CTRL));
   assign hit_key    = (bus_addr == ADDR_W'(ADR_KEY));
   assign hit_feed   = (bus_addr == ADDR_W'(ADR_FEED));
   assign hit_count  = (bus_addr == ADDR_W'(ADR_COUNT));
   assign hit_scaled = (bus_addr == ADDR_W'(ADR_SCALED));
   assign hit_cmp    = (bus_addr == ADDR_W'(ADR_CMP));

   logic prot_wr, key_open;
   assign prot_wr = bus_wr & (hit_ctrl | hit_feed | hit_count | hit_scaled | hit_cmp);

   wdt_wstb_t wstb;
   assign wstb.ctrl   = bus_wr & key_open & hit_ctrl;
   assign wstb.feed   = bus_wr & key_open & hit_feed;
   assign wstb.count  = bus_wr & key_open & hit_count;
   assign wstb.scaled = bus_wr & key_open & hit_scaled;
   assign wstb.cmp    = bus_wr & key_open & hit_cmp;

   wdt_keylock #(.KEY_W(BUS_W), .KEY_VAL(KEY_VAL)) u_lock (
      .clk      (clk),
      .rst_n    (rst_n),
      .key_wr   (bus_wr & hit_key),
      .key_data (bus_wdata),
      .prot_wr  (prot_wr),
      .key_open (key_open)
   );

   // Control and compare registers
   logic [SCALE_W-1:0] scale_q;
   logic               rsten_q, zero_q, always_q, awake_q;
   logic [CMP_W-1:0]   cmp_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scale_q  <= '0;
         rsten_q  <= 1'b0;
         zero_q   <= 1'b0;
         always_q <= 1'b0;
         awake_q  <= 1'b0;
      end else if (wstb.ctrl) begin
         scale_q  <= bus_wdata[SCALE_W-1:0];
         rsten_q  <= bus_wdata[CB_RSTEN];
         zero_q   <= bus_wdata[CB_ZERO];
         always_q <= bus_wdata[CB_ALWAYS];
         awake_q  <= bus_wdata[CB_AWAKE];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cmp_q <= '1;
      else if (wstb.cmp) cmp_q <= bus_wdata[CMP_W-1:0];
   end

   logic [CNT_W-1:0] count;
   logic [CMP_W-1:0] scaled;
   logic             match, ip;

   wdt_counter #(
      .CNT_W(CNT_W), .CMP_W(CMP_W), .SCALE_W(SCALE_W), .HAS_AWAKE(HAS_AWAKE)
   ) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_always (always_q),
      .run_awake  (awake_q),
      .core_rst   (core_rst),
      .load       (wstb.count),
      .load_val   (bus_wdata[CNT_W-1:0]),
      .clear      (wstb.feed | (match & zero_q)),
      .scale      (scale_q),
      .count      (count),
      .scaled     (scaled)
   );

   wdt_compare #(.CMP_W(CMP_W)) u_cmp (
      .clk      (clk),
      .rst_n    (rst_n),
      .scaled   (scaled),
      .cmp      (cmp_q),
      .rst_en   (rsten_q),
      .ip_wr    (wstb.ctrl),
      .ip_wdata (bus_wdata[CB_IP]),
      .match    (match),
      .ip       (ip),
      .rst_req  (wdt_rst_req)
   );

   assign wdt_irq = ip;

   // Read mux; FEED and unused addresses read zero, SCALED is a read view
   always_comb begin
      bus_rdata = '0;
      if (hit_ctrl) begin
         bus_rdata[SCALE_W-1:0] = scale_q;
         bus_rdata[CB_RSTEN]    = rsten_q;
         bus_rdata[CB_ZERO]     = zero_q;
         bus_rdata[CB_ALWAYS]   = always_q;
         bus_rdata[CB_AWAKE]    = awake_q;
         bus_rdata[CB_IP]       = ip;
      end else if (hit_key) begin
         bus_rdata[0] = key_open;
      end else if (hit_count) begin
         bus_rdata[CNT_W-1:0] = count;
      end else if (hit_scaled) begin
         bus_rdata[CMP_W-1:0] = scaled;
      end else if (hit_cmp) begin
         bus_rdata[CMP_W-1:0] = cmp_q;
      end
   end

   AST_LOCKED_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_cmp && !key_open) |=> $stable(cmp_q)); // R3
   AST_LOCKED_SCALE: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_ctrl && !key_open) |=> $stable(scale_q)); // R3
   AST_SCALED_NOP_CMP: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && hit_scaled) |=> $stable(cmp_q)); // R11
endmodule

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;
   localparam int CLK_PERIOD = 10;
   localparam logic [31:0] MAGIC = 32'h0051_F15E;
   localparam longint CMASK = 64'h7FFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        core_rst = 1'b0;
   logic        bus_wr = 1'b0;
   logic [2:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        wdt_irq, wdt_rst_req;

   int n_run = 0, n_fail = 0;
   int cycles = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wdt_keyed u_dut (
      .clk(clk), .rst_n(rst_n), .core_rst(core_rst),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .wdt_irq(wdt_irq), .wdt_rst_req(wdt_rst_req)
   );

   // Behavioural reference model
   longint m_cnt;
   int m_scale, m_cmp;
   bit m_rsten, m_zero, m_always, m_awake, m_ip, m_key, m_rst, m_pmatch;

   function automatic longint m_scaled();
      return (m_cnt >> m_scale) & 64'hFFFF;
   endfunction

   function automatic logic [31:0] m_read(input int a);
      case (a)
         0: return 32'(m_scale) | (32'(m_rsten) << 8) | (32'(m_zero) << 9) |
                   (32'(m_always) << 12) | (32'(m_awake) << 13) | (32'(m_ip) << 28);
         1: return 32'(m_key);
         3: return 32'(m_cnt);
         4: return 32'(m_scaled());
         5: return 32'(m_cmp);
         default: return 32'h0;
      endcase
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 0; m_scale = 0; m_cmp = 'hFFFF; m_rsten = 0; m_zero = 0;
         m_always = 0; m_awake = 0; m_ip = 0; m_key = 0; m_rst = 0; m_pmatch = 0;
      end else begin
         bit match, en, prot, ok, nkey, nip;
         int a;
         a = int'(bus_addr);
         match = (m_scaled() >= m_cmp);
         en = m_always || (m_awake && !core_rst);
         prot = bus_wr && (a == 0 || a == 2 || a == 3 || a == 4 || a == 5);
         ok = prot && m_key;
         nkey = m_key;
         if (bus_wr && a == 1) nkey = (bus_wdata == MAGIC);
         else if (prot) nkey = 0;
         m_rst = m_rsten && match && !m_pmatch;
         m_pmatch = match;
         nip = (ok && a == 0) ? bus_wdata[28] : m_ip;
         m_ip = nip | match;
         if (ok && a == 3) m_cnt = longint'(bus_wdata) & CMASK;
         else if (ok && a == 2) m_cnt = 0;
         else if (match && m_zero) m_cnt = 0;
         else if (en) m_cnt = (m_cnt + 1) & CMASK;
         if (ok && a == 0) begin
            m_scale = int'(bus_wdata[3:0]); m_rsten = bus_wdata[8]; m_zero = bus_wdata[9];
            m_always = bus_wdata[12]; m_awake = bus_wdata[13];
         end
         if (ok && a == 5) m_cmp = int'(bus_wdata[15:0]);
         m_key = nkey;
      end
   end

   // Per-cycle comparison of the outputs
   always @(negedge clk) begin
      if (rst_n && !done) begin
         n_run++;
         if (wdt_irq !== m_ip) begin
            n_fail++;
            $display("FAIL R8 irq: actual %0b expected %0b at cycle %0d", wdt_irq, m_ip, cycles);
         end
         n_run++;
         if (wdt_rst_req !== m_rst) begin
            n_fail++;
            $display("FAIL R9 rst_req: actual %0b expected %0b at cycle %0d", wdt_rst_req, m_rst, cycles);
         end
      end
   end

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = 3'(a); bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input int a, input string tag);
      logic [31:0] exp;
      bus_addr = 3'(a);
      #1;
      exp = m_read(a);
      n_run++;
      if (bus_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s read addr %0d: actual 0x%08h expected 0x%08h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic rd_val(input int a, input logic [31:0] exp, input string tag);
      bus_addr = 3'(a);
      #1;
      n_run++;
      if (bus_rdata !== exp) begin
         n_fail++;
         $display("FAIL %s read addr %0d: actual 0x%08h expected 0x%08h", tag, a, bus_rdata, exp);
      end
   endtask

   task automatic pwr(input int a, input logic [31:0] d);
      wr(1, MAGIC);
      wr(a, d);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000 && !done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      // R1 reset state
      rd_val(0, 32'h0, "R1"); rd_val(1, 32'h0, "R1");
      rd_val(3, 32'h0, "R1"); rd_val(5, 32'h0000_FFFF, "R1");
      // R3 locked write ignored
      wr(5, 32'h1234);
      rd_val(5, 32'h0000_FFFF, "R3");
      // R2 unlock and wrong key
      wr(1, MAGIC);       rd_val(1, 32'h1, "R2");
      wr(1, 32'h0051_F15F); rd_val(1, 32'h0, "R2");
      wr(1, MAGIC);
      wr(5, 32'h0010);    rd_val(5, 32'h10, "R3");
      rd_val(1, 32'h0, "R3");
      wr(5, 32'h0020);    rd_val(5, 32'h10, "R3");
      // R4 count write near top, wrap while running
      pwr(3, 32'hFFFF_FFF8);
      rd_val(3, 32'h7FFF_FFF8, "R4");
      pwr(5, 32'hFFFF);
      pwr(0, 32'h0000_1000);
      idle(12);
      rd(3, "R4"); rd(0, "R5");
      // R6 feed clears the count
      pwr(2, 32'hDEAD_BEEF);
      rd(3, "R6");
      // R11 scaled write consumes key but changes nothing
      wr(1, MAGIC);
      wr(4, 32'hFFFF_FFFF);
      rd(1, "R11"); rd(5, "R11"); rd(0, "R11");
      // R5 awake-only mode with core_rst toggling
      pwr(3, 32'h0);
      pwr(0, 32'h0000_2000);
      idle(5); rd(3, "R5");
      core_rst = 1'b1; idle(6); rd(3, "R5");
      core_rst = 1'b0; idle(4); rd(3, "R5");
      // R5 neither enable: hold
      pwr(0, 32'h0);
      idle(5); rd(3, "R5");
      // R7 scaled windows
      pwr(3, 32'h1234_5678);
      for (int s = 0; s < 16; s += 5) begin
         pwr(0, 32'(s));
         rd(4, "R7");
      end
      // R8 match sets ip; clear via CTRL write
      pwr(3, 32'h0);
      pwr(5, 32'h0008);
      pwr(0, 32'h0000_1000);
      idle(12); rd(0, "R8");
      pwr(5, 32'hFFFF);
      pwr(0, 32'h0000_1000);
      rd(0, "R8");
      // R9 / R10 periodic reset pulses with zero-on-match
      pwr(3, 32'h0);
      pwr(5, 32'h0003);
      pwr(0, 32'h0000_1302);
      idle(45); rd(3, "R10"); rd(0, "R9");
      // R9 reset disabled: no pulse
      pwr(0, 32'h0000_1202);
      idle(30); rd(3, "R10");
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule